// File: doc/BRIEF.md
# Segment and I/O Privilege Gate

This block decides whether one protected-mode access may go ahead. A request carries the current code level, the level requested by the selector, the level of the target descriptor, the I/O privilege field, a real-mode flag, a flag giving the width of the task-state structure, an operation class, and, for port I/O, a port number and a byte count. All levels are two bits wide. Level 0 is the most privileged and level 3 the least.

The block answers with a one-cycle `grant` or `fault` pulse and reports the effective level it used. Port I/O from an under-privileged task that has a 32-bit task-state structure cannot be settled from the levels alone. In that case the block raises a lookup request carrying the port number and a byte mask. It then waits for the per-port permission bits from an outside reader and decides from those bits. Only one request is in flight at a time.

Top module: `priv_gate`

## Requirements
- R1: While `rst_n` is low, `grant`, `fault` and `bm_req` are 0. `eff_lvl`, `bm_port` and `bm_mask` are 0.
- R2: A request is accepted when `req_valid` is 1 and `bm_req` is 0. On the clock edge that accepts it, `eff_lvl` takes the larger of `sel_lvl` and the working current level. The working current level is `cur_lvl`, or 0 when `real_mode` is 1. `eff_lvl` then holds until the next accepted request.
- R3: For `req_op` = 0 (data segment access), the cycle after acceptance shows a `grant` pulse when `eff_lvl` ≤ `dsc_lvl`. Otherwise it shows a `fault` pulse.
- R4: For `req_op` 1, 2 or 3 (I/O-sensitive), a working current level ≤ `io_lvl` gives a `grant` pulse the cycle after acceptance.
- R5: For `req_op` 1, 2 or 3, when the working current level is > `io_lvl` and `tss32` = 0, the cycle after acceptance shows a `fault` pulse.
- R6: For `req_op` 2 or 3 (interrupt-flag operations), when the working current level is > `io_lvl` and `tss32` = 1, the cycle after acceptance shows a `fault` pulse.
- R7: For `req_op` = 1 (port I/O), when the working current level is > `io_lvl` and `tss32` = 1, no verdict is given. `bm_req` goes high from the cycle after acceptance, with `bm_port` equal to `req_port`. `bm_mask` covers 1, 2 or 4 bytes for `req_size` 0, 1 or 2/3 respectively, as bits [0], [1:0] or [3:0]. These outputs hold until the response.
- R8: On the edge where `bm_req` and `bm_rsp_valid` are both 1, `bm_req` drops. The following cycle shows a `grant` pulse if every `bm_rsp_bits` bit selected by `bm_mask` is 0. Otherwise it shows a `fault` pulse.
- R9: `grant` and `fault` are registered and never 1 in the same cycle. Neither is 1 while `bm_req` is 1.
- R10: `req_valid` is ignored while `bm_req` is 1. `bm_rsp_valid` is ignored while `bm_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 data, 1 port I/O, 2/3 interrupt-flag operation |
| cur_lvl | input | 2 | Current code privilege level |
| sel_lvl | input | 2 | Selector requested level |
| dsc_lvl | input | 2 | Descriptor level |
| io_lvl | input | 2 | I/O privilege field |
| real_mode | input | 1 | Real mode: current level treated as 0 |
| tss32 | input | 1 | 1 = 32-bit task-state structure |
| req_port | input | 16 | Port number for port I/O |
| req_size | input | 2 | Port access width code |
| bm_rsp_valid | input | 1 | Permission bits valid |
| bm_rsp_bits | input | 4 | Permission bits, one per byte |
| grant | output | 1 | Access allowed pulse |
| fault | output | 1 | General-protection fault pulse |
| eff_lvl | output | 2 | Effective level of last accepted request |
| bm_req | output | 1 | Lookup pending |
| bm_port | output | 16 | Port number to look up |
| bm_mask | output | 4 | Bytes covered by the access |

## Verification
Two events can meet on one edge: a bitmap response closing a pending lookup, and a new request that arrives while that lookup is still open. The bench drives `req_valid` with random operands on every cycle. Responses arrive after random delays, so responses and stray requests often land on the same edge. Responses are also sent while nothing is pending. The reference model expects exactly one verdict from the response and none from the colliding request, and every cycle is compared against it.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef enum logic [1:0] {
    OP_DATA  = 2'd0,
    OP_PORT  = 2'd1,
    OP_FLAG  = 2'd2,
    OP_FLAG2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    V_ALLOW  = 2'd0,
    V_FAULT  = 2'd1,
    V_LOOKUP = 2'd2
  } verdict_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } gate_st_e;
endpackage

// File: rtl/priv_eff_lvl.sv
module priv_eff_lvl #(
  parameter int LVL_W = 2
) (
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic [LVL_W-1:0] sel_lvl,
  input  logic             real_mode,
  output logic [LVL_W-1:0] cur_work,
  output logic [LVL_W-1:0] eff_lvl
);
  always_comb begin
    cur_work = real_mode ? '0 : cur_lvl;
    eff_lvl  = (sel_lvl > cur_work) ? sel_lvl : cur_work;
  end
endmodule

// File: rtl/priv_verdict.sv
module priv_verdict
  import priv_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  op_e              op,
  input  logic [LVL_W-1:0] cur_work,
  input  logic [LVL_W-1:0] eff_lvl,
  input  logic [LVL_W-1:0] dsc_lvl,
  input  logic [LVL_W-1:0] io_lvl,
  input  logic             tss32,
  output verdict_e         verdict
);
  logic io_ok;

  always_comb begin
    io_ok = (cur_work <= io_lvl);
    if (op == OP_DATA) begin
      verdict = (eff_lvl <= dsc_lvl) ? V_ALLOW : V_FAULT;
    end else if (io_ok) begin
      verdict = V_ALLOW;
    end else if (!tss32) begin
      verdict = V_FAULT;
    end else if (op == OP_PORT) begin
      verdict = V_LOOKUP;
    end else begin
      verdict = V_FAULT;
    end
  end

  // R5: a 16-bit task structure never leads to a bitmap lookup
  always_comb begin
    if (!tss32) p_no_lookup_tss16_r5: assert (verdict != V_LOOKUP);
  end
endmodule

// File: rtl/priv_port_mask.sv
module priv_port_mask #(
  parameter int MAX_BYTES = 4
) (
  input  logic [1:0]           size,
  output logic [MAX_BYTES-1:0] mask
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  logic [CNT_W-1:0] nbytes;

  always_comb begin
    case (size)
      2'd0:    nbytes = CNT_W'(1);
      2'd1:    nbytes = CNT_W'(2);
      default: nbytes = CNT_W'(4);
    endcase
    if (nbytes > CNT_W'(MAX_BYTES)) nbytes = CNT_W'(MAX_BYTES);
  end

  for (genvar gi = 0; gi < MAX_BYTES; gi++) begin : g_bit
    assign mask[gi] = (CNT_W'(gi) < nbytes);
  end
endmodule

// File: rtl/priv_gate.sv
module priv_gate
  import priv_pkg::*;
#(
  parameter int LVL_W     = 2,
  parameter int PORT_W    = 16,
  parameter int MAX_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [LVL_W-1:0]     cur_lvl,
  input  logic [LVL_W-1:0]     sel_lvl,
  input  logic [LVL_W-1:0]     dsc_lvl,
  input  logic [LVL_W-1:0]     io_lvl,
  input  logic                 real_mode,
  input  logic                 tss32,
  input  logic [PORT_W-1:0]    req_port,
  input  logic [1:0]           req_size,
  input  logic                 bm_rsp_valid,
  input  logic [MAX_BYTES-1:0] bm_rsp_bits,
  output logic                 grant,
  output logic                 fault,
  output logic [LVL_W-1:0]     eff_lvl,
  output logic                 bm_req,
  output logic [PORT_W-1:0]    bm_port,
  output logic [MAX_BYTES-1:0] bm_mask
);
  gate_st_e             st_q, st_d;
  logic                 grant_d, fault_d;
  logic [LVL_W-1:0]     eff_q, eff_d, cur_work, eff_c;
  logic [PORT_W-1:0]    port_q, port_d;
  logic [MAX_BYTES-1:0] mask_q, mask_d, mask_c;
  logic                 accept, load_en;
  verdict_e             verdict;

  priv_eff_lvl #(.LVL_W(LVL_W)) u_eff (
    .cur_lvl(cur_lvl), .sel_lvl(sel_lvl), .real_mode(real_mode),
    .cur_work(cur_work), .eff_lvl(eff_c)
  );

  priv_verdict #(.LVL_W(LVL_W)) u_verdict (
    .op(op_e'(req_op)), .cur_work(cur_work), .eff_lvl(eff_c),
    .dsc_lvl(dsc_lvl), .io_lvl(io_lvl), .tss32(tss32), .verdict(verdict)
  );

  priv_port_mask #(.MAX_BYTES(MAX_BYTES)) u_mask (
    .size(req_size), .mask(mask_c)
  );

  assign accept  = req_valid && (st_q == ST_IDLE);
  assign load_en = accept;

  always_comb begin
    st_d    = st_q;
    grant_d = 1'b0;
    fault_d = 1'b0;
    eff_d   = eff_q;
    port_d  = port_q;
    mask_d  = mask_q;
    if (accept) begin
      eff_d = eff_c;
      case (verdict)
        V_ALLOW: grant_d = 1'b1;
        V_FAULT: fault_d = 1'b1;
        default: begin
          st_d   = ST_WAIT;
          port_d = req_port;
          mask_d = mask_c;
        end
      endcase
    end else if ((st_q == ST_WAIT) && bm_rsp_valid) begin
      st_d = ST_IDLE;
      if (|(bm_rsp_bits & mask_q)) fault_d = 1'b1;
      else                         grant_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      grant <= 1'b0;
      fault <= 1'b0;
    end else begin
      st_q  <= st_d;
      grant <= grant_d;
      fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q  <= '0;
      port_q <= '0;
      mask_q <= '0;
    end else if (load_en) begin
      eff_q  <= eff_d;
      port_q <= port_d;
      mask_q <= mask_d;
    end
  end

  assign eff_lvl = eff_q;
  assign bm_req  = (st_q == ST_WAIT);
  assign bm_port = port_q;
  assign bm_mask = mask_q;

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && fault));
  p_quiet_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> !grant && !fault);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && !bm_rsp_valid) |=> bm_req && $stable(bm_port) && $stable(bm_mask));
  p_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_rsp_valid) |=> !bm_req && (grant || fault));
  p_eff_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bm_req) |=> eff_lvl >= $past(sel_lvl));
  p_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bm_req && !req_valid) |=> !grant && !fault);
endmodule

// File: tb/priv_gate_tb.sv
`timescale 1ns/1ps
module priv_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op, cur_lvl, sel_lvl, dsc_lvl, io_lvl, req_size;
  logic        real_mode, tss32, bm_rsp_valid;
  logic [15:0] req_port;
  logic [3:0]  bm_rsp_bits;
  logic        grant, fault, bm_req;
  logic [1:0]  eff_lvl;
  logic [15:0] bm_port;
  logic [3:0]  bm_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  priv_gate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .cur_lvl(cur_lvl), .sel_lvl(sel_lvl), .dsc_lvl(dsc_lvl), .io_lvl(io_lvl),
    .real_mode(real_mode), .tss32(tss32), .req_port(req_port),
    .req_size(req_size), .bm_rsp_valid(bm_rsp_valid), .bm_rsp_bits(bm_rsp_bits),
    .grant(grant), .fault(fault), .eff_lvl(eff_lvl), .bm_req(bm_req),
    .bm_port(bm_port), .bm_mask(bm_mask)
  );

  // Behavioural reference model
  bit        m_wait, m_grant, m_fault;
  int        m_eff, m_port, m_mask;
  string     m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0; m_grant = 0; m_fault = 0;
      m_eff = 0; m_port = 0; m_mask = 0; m_tag = "R1";
    end else begin
      int ce, ef, nb;
      m_grant = 0; m_fault = 0;
      if (m_wait) begin
        if (bm_rsp_valid) begin
          m_wait = 0; m_tag = "R8";
          if ((int'(bm_rsp_bits) & m_mask) != 0) m_fault = 1; else m_grant = 1;
        end else if (req_valid) m_tag = "R10";
      end else if (req_valid) begin
        ce = real_mode ? 0 : int'(cur_lvl);
        ef = (int'(sel_lvl) > ce) ? int'(sel_lvl) : ce;
        m_eff = ef;
        if (req_op == 2'd0) begin
          m_tag = "R3";
          if (ef <= int'(dsc_lvl)) m_grant = 1; else m_fault = 1;
        end else if (ce <= int'(io_lvl)) begin
          m_tag = "R4"; m_grant = 1;
        end else if (!tss32) begin
          m_tag = "R5"; m_fault = 1;
        end else if (req_op != 2'd1) begin
          m_tag = "R6"; m_fault = 1;
        end else begin
          m_tag = "R7"; m_wait = 1; m_port = int'(req_port);
          nb = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4;
          m_mask = (1 << nb) - 1;
        end
      end else if (bm_rsp_valid) m_tag = "R10";
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(grant == m_grant, m_tag, grant, m_grant);
      chk(fault == m_fault, m_tag, fault, m_fault);
      chk(!(grant && fault), "R9", {grant, fault}, 0);
      chk(int'(eff_lvl) == m_eff, "R2", eff_lvl, m_eff);
      chk(bm_req == m_wait, "R7", bm_req, m_wait);
      if (m_wait) begin
        chk(int'(bm_port) == m_port, "R7", bm_port, m_port);
        chk(int'(bm_mask) == m_mask, "R7", bm_mask, m_mask);
      end
    end
  end

  task automatic drive(input bit v, input int op, input int cur, input int sel,
                       input int dsc, input int iop, input bit rm, input bit t32,
                       input int port, input int sz);
    req_valid = v; req_op = 2'(op); cur_lvl = 2'(cur); sel_lvl = 2'(sel);
    dsc_lvl = 2'(dsc); io_lvl = 2'(iop); real_mode = rm; tss32 = t32;
    req_port = 16'(port); req_size = 2'(sz);
  endtask

  task automatic respond(input bit v, input int bits);
    bm_rsp_valid = v; bm_rsp_bits = 4'(bits);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    respond(0, 0);
    #2;
    // R1: reset state
    chk(!grant && !fault && !bm_req, "R1", {grant, fault, bm_req}, 0);
    chk(eff_lvl == 0 && bm_port == 0 && bm_mask == 0, "R1", eff_lvl, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: data access, eff 2 vs dsc 2 -> grant; eff 3 vs dsc 1 -> fault
    drive(1, 0, 1, 2, 2, 0, 0, 1, 0, 0); @(negedge clk);
    drive(1, 0, 3, 0, 1, 0, 0, 1, 0, 0); @(negedge clk);
    // R2/R4: real mode forces level 0 -> port op granted
    drive(1, 1, 3, 1, 0, 0, 1, 1, 5, 0); @(negedge clk);
    // R5: 16-bit structure, cur 3 > iopl 0 -> fault
    drive(1, 1, 3, 0, 0, 0, 0, 0, 5, 0); @(negedge clk);
    // R6: flag op, 32-bit structure -> fault
    drive(1, 2, 3, 0, 0, 1, 0, 1, 5, 0); @(negedge clk);
    // R7/R8: 4-byte port access, high byte denied
    drive(1, 1, 3, 0, 0, 1, 0, 1, 16'h3f8, 2); @(negedge clk);
    // R10: request while waiting is ignored
    drive(1, 0, 0, 0, 3, 0, 0, 1, 0, 0); @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); respond(1, 4'b1000); @(negedge clk);
    respond(0, 0); @(negedge clk);
    // R7/R8: 2-byte access, bit above mask set -> grant
    drive(1, 1, 2, 0, 0, 1, 0, 1, 16'h80, 1); @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); respond(1, 4'b0100); @(negedge clk);
    // R10: stray response with no lookup pending
    respond(1, 4'b1111); @(negedge clk);
    respond(0, 0); @(negedge clk);
    // Random traffic, responses with random delay, collisions with requests
    for (int i = 0; i < 6000; i++) begin
      drive($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            ($urandom_range(0, 7) == 0), $urandom_range(0, 1),
            $urandom_range(0, 65535), $urandom_range(0, 3));
      if (bm_req || ($urandom_range(0, 9) == 0))
        respond(($urandom_range(0, 2) == 0),
                ($urandom_range(0, 1) == 1) ? 0 : $urandom_range(0, 15));
      else
        respond(0, 0);
      @(negedge clk);
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); respond(0, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule